// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This block runs on the host side of a parallel NOR flash. A program or erase command has already been written to the device. The block then works out whether the device's embedded operation finished or failed. It issues status reads over a request/acknowledge bus and captures two status bytes one after the other. If the toggle bit differs between the two bytes, the device is still busy. If the toggle bit is toggling and the device also shows its timing-limit flag, the block takes one more pair of reads. This recheck covers the case where the toggling stops at the same moment the flag rises. If the recheck still shows toggling, the block writes the reset command, which returns the device to array reads, and then reports failure.

A client starts the poller with a pulse on `start` and watches `busy`. The block ends every run with exactly one of three one-cycle pulses: `done`, `fail` or `timeout`. The client can abandon a run with `abort`. A later `start` always begins again from the first read of a new pair, with the poll budget cleared.

The bus port follows valid/ready rules. `bus_req` is the valid. `bus_ack` is the ready, and it may stay low for any number of cycles to apply back-pressure. A transaction completes on a rising clock edge where both `bus_req` and `bus_ack` are high. While `bus_req` is high without `bus_ack`, the block holds `bus_req`, `bus_we` and `bus_wdata` steady. On a read, `bus_rdata` is taken on the completing edge. Read transactions may follow each other back to back with no idle cycle between them.

Top module: `tbit_poller`

## Requirements
- R1: After reset, `bus_req`, `busy`, `done`, `fail` and `timeout` are all low.
- R2: A `start` seen while idle raises `busy` on the next cycle and begins a pair of read transactions. A `start` seen while busy is ignored.
- R3: In a pair, the operation counts as toggling when bit 6 of the first byte differs from bit 6 of the second byte. If it is not toggling, `done` pulses for one cycle, `busy` drops in that same cycle, and no write is issued. Bit 5 is then disregarded.
- R4: If a pair toggles and bit 5 of its second byte is 0, the block reads another pair.
- R5: If a pair toggles and bit 5 of its second byte is 1, the block reads one recheck pair. If bit 6 is steady in the recheck, `done` pulses.
- R6: If the recheck pair still toggles, the block issues one write of data 0xF0 (`bus_we` high). `fail` pulses in the cycle after the edge that completes that write, never before it.
- R7: If MAX_POLLS main pairs in a row toggle with bit 5 clear, `timeout` pulses, `busy` drops, and no write is issued.
- R8: `abort` takes effect when the current read transaction completes: `busy` drops and no result pulse fires. A later `start` restarts from the first read of a new pair with the poll count cleared.
- R9: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we` and `bus_wdata` keep their values into the next cycle.
- R10: `done`, `fail` and `timeout` are one-cycle pulses, at most one at a time, and each coincides with `busy` going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| start | input | 1 | Begin a status-polling run |
| abort | input | 1 | Abandon the current run |
| bus_req | output | 1 | Bus transaction request (valid) |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | DW | Write data (the reset command) |
| bus_ack | input | 1 | Bus acknowledge (ready) |
| bus_rdata | input | DW | Status byte, sampled on the completing edge |
| busy | output | 1 | Run in progress |
| done | output | 1 | Pulse: operation completed |
| fail | output | 1 | Pulse: operation failed, reset command sent |
| timeout | output | 1 | Pulse: poll budget used up |

## Verification
The bench builds the block with MAX_POLLS = 4, so a timeout arrives after eight reads. This puts the poll-budget boundary within reach of a short directed test. The bench's bus responder switches between zero and two wait states. Zero wait states exercise back-to-back reads. Two wait states exercise back-pressure hold, a reset write that is held before its acknowledge, and an abort raised while a read is still pending.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_A,
    S_RD_B,
    S_RC_A,
    S_RC_B,
    S_RST
  } tbp_state_t;
endpackage

// File: rtl/tbp_pair_eval.sv
module tbp_pair_eval #(
  parameter int DW         = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int LIMIT_BIT  = 5
) (
  input  logic [DW-1:0] first_byte,
  input  logic [DW-1:0] second_byte,
  output logic          toggled,
  output logic          limit_hit
);
  localparam logic [DW-1:0] TOG_MASK = DW'(1) << TOGGLE_BIT;
  localparam logic [DW-1:0] LIM_MASK = DW'(1) << LIMIT_BIT;

  always_comb begin
    toggled   = |((first_byte ^ second_byte) & TOG_MASK);
    limit_hit = |(second_byte & LIM_MASK);
  end
endmodule

// File: rtl/tbp_poll_ctr.sv
module tbp_poll_ctr #(
  parameter int MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + CW'(1);
  end

  assign at_last = (cnt_q == CW'(MAX_POLLS - 1));

  // R7: the budget counter never passes the last allowed pair
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAX_POLLS));
endmodule

// File: rtl/tbp_bus_port.sv
module tbp_bus_port #(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] RESET_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_read,
  input  logic          do_write,
  input  logic          cap_first,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] first_q
);
  assign bus_req   = do_read | do_write;
  assign bus_we    = do_write;
  assign bus_wdata = do_write ? RESET_CMD : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     first_q <= '0;
    else if (cap_first && bus_ack)  first_q <= bus_rdata;
  end

  // R9: a pending request keeps its control and data until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_wdata)));
endmodule

// File: rtl/tbit_poller.sv
module tbit_poller #(
  parameter int            DW         = 8,
  parameter int            TOGGLE_BIT = 6,
  parameter int            LIMIT_BIT  = 5,
  parameter int            MAX_POLLS  = 1024,
  parameter logic [DW-1:0] RESET_CMD  = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  output logic          bus_req,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          timeout
);
  import tbp_pkg::*;

  tbp_state_t state_q, state_d;
  logic       abort_q;
  logic       done_d, fail_d, to_d;
  logic       cnt_clr, cnt_inc, at_last;
  logic       toggled, limit_hit;
  logic       do_read, do_write, cap_first;
  logic       stop;
  logic [DW-1:0] first_q;

  assign do_read   = (state_q == S_RD_A) || (state_q == S_RD_B) ||
                     (state_q == S_RC_A) || (state_q == S_RC_B);
  assign do_write  = (state_q == S_RST);
  assign cap_first = (state_q == S_RD_A) || (state_q == S_RC_A);
  assign stop      = abort | abort_q;

  tbp_bus_port #(.DW(DW), .RESET_CMD(RESET_CMD)) u_port (
    .clk(clk), .rst_n(rst_n), .do_read(do_read), .do_write(do_write),
    .cap_first(cap_first), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata), .first_q(first_q)
  );

  tbp_pair_eval #(.DW(DW), .TOGGLE_BIT(TOGGLE_BIT), .LIMIT_BIT(LIMIT_BIT)) u_eval (
    .first_byte(first_q), .second_byte(bus_rdata),
    .toggled(toggled), .limit_hit(limit_hit)
  );

  tbp_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .at_last(at_last)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    to_d    = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        state_d = S_RD_A;
        cnt_clr = 1'b1;
      end
      S_RD_A: if (bus_ack) state_d = stop ? S_IDLE : S_RD_B;
      S_RD_B: if (bus_ack) begin
        if (stop)            state_d = S_IDLE;
        else if (!toggled) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else if (limit_hit) state_d = S_RC_A;
        else if (at_last) begin
          state_d = S_IDLE;
          to_d    = 1'b1;
        end else begin
          state_d = S_RD_A;
          cnt_inc = 1'b1;
        end
      end
      S_RC_A: if (bus_ack) state_d = stop ? S_IDLE : S_RC_B;
      S_RC_B: if (bus_ack) begin
        if (stop)          state_d = S_IDLE;
        else if (!toggled) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else           state_d = S_RST;
      end
      S_RST: if (bus_ack) begin
        state_d = S_IDLE;
        fail_d  = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      abort_q <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      fail    <= fail_d;
      timeout <= to_d;
      if (state_d == S_IDLE || state_q == S_RST) abort_q <= 1'b0;
      else if (abort && do_read)                 abort_q <= 1'b1;
    end
  end

  assign busy = (state_q != S_IDLE);

  // R10: result pulses are exclusive and single-cycle
  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail, timeout}));
  p_pulse_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail || timeout) |=> !(done || fail || timeout));
  p_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail || timeout) |-> !busy);
  // R2: start from idle raises busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R6: failure only follows a completed reset write
  p_fail_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(bus_req && bus_we && bus_ack));
  // R3: a done pulse follows a completed read, never a write
  p_done_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_req && !bus_we && bus_ack));
endmodule

// File: tb/test_tbit_poller.sv
module test_tbit_poller;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       abort = 1'b0;
  logic       bus_req, bus_we, bus_ack;
  logic [7:0] bus_wdata, bus_rdata;
  logic       busy, done, fail, timeout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] script [0:15];
  int idx = 0, wait_lim = 0, wait_cnt = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, fail_cnt = 0, to_cnt = 0, early_fail = 0;
  logic [7:0] last_wdata = 8'h00;

  always #4 clk = ~clk;  // 125 MHz

  tbit_poller #(.MAX_POLLS(4)) i_tbit_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .fail(fail), .timeout(timeout)
  );

  // bus responder: drives ack/rdata at the falling edge
  initial begin
    bus_ack = 1'b0;
    bus_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (bus_req) begin
        if (wait_cnt >= wait_lim) begin
          bus_ack = 1'b1;
          wait_cnt = 0;
          if (!bus_we) begin
            bus_rdata = script[idx];
            idx = idx + 1;
          end
        end else begin
          bus_ack = 1'b0;
          wait_cnt = wait_cnt + 1;
        end
      end else begin
        bus_ack = 1'b0;
        wait_cnt = 0;
      end
    end
  end

  // transaction monitor
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (bus_req && bus_ack) begin
      if (bus_we) begin
        wr_cnt <= wr_cnt + 1;
        last_wdata <= bus_wdata;
      end else rd_cnt <= rd_cnt + 1;
    end
  end

  // result pulse monitor
  always @(negedge clk) begin
    if (done)    done_cnt = done_cnt + 1;
    if (timeout) to_cnt = to_cnt + 1;
    if (fail) begin
      fail_cnt = fail_cnt + 1;
      if (wr_cnt == 0) early_fail = early_fail + 1;
    end
  end

  // watchdog
  initial begin
    #800000;
    errors = errors + 1;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    idx = 0; rd_cnt = 0; wr_cnt = 0; done_cnt = 0; fail_cnt = 0; to_cnt = 0; early_fail = 0;
    last_wdata = 8'h00;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(!bus_req && !busy && !done && !fail && !timeout, "R1 reset outputs",
          {bus_req, busy, done, fail, timeout}, 0);
  endtask

  task automatic t_steady();
    clear_counts(); wait_lim = 0;
    script[0] = 8'h40; script[1] = 8'h40;
    pulse_start();
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    wait_idle();
    check(done_cnt == 1 && fail_cnt == 0 && to_cnt == 0, "R3 steady done", done_cnt, 1);
    check(rd_cnt == 2 && wr_cnt == 0, "R3 steady reads", rd_cnt, 2);
    // bit 5 set but not toggling
    clear_counts();
    script[0] = 8'h20; script[1] = 8'h20;
    pulse_start(); wait_idle();
    check(done_cnt == 1 && wr_cnt == 0, "R3 limit bit disregarded", done_cnt, 1);
  endtask

  task automatic t_repoll();
    clear_counts(); wait_lim = 0;
    script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h00;
    script[3] = 8'h40; script[4] = 8'h40; script[5] = 8'h40;
    pulse_start();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;  // ignored
    wait_idle();
    check(rd_cnt == 6, "R4 repoll read count", rd_cnt, 6);
    check(done_cnt == 1 && wr_cnt == 0, "R2 start while busy ignored", done_cnt, 1);
  endtask

  task automatic t_recheck_ok();
    clear_counts(); wait_lim = 0;
    script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h20; script[3] = 8'h20;
    pulse_start(); wait_idle();
    check(rd_cnt == 4 && done_cnt == 1, "R5 recheck done reads", rd_cnt, 4);
    check(wr_cnt == 0 && fail_cnt == 0, "R5 recheck no write", wr_cnt, 0);
  endtask

  task automatic t_recheck_fail();
    clear_counts(); wait_lim = 2;
    script[0] = 8'h00; script[1] = 8'h60; script[2] = 8'h20; script[3] = 8'h60;
    pulse_start(); wait_idle();
    check(rd_cnt == 4 && wr_cnt == 1, "R6 reads then one write", wr_cnt, 1);
    check(last_wdata == 8'hF0, "R6 reset data", last_wdata, 8'hF0);
    check(fail_cnt == 1 && done_cnt == 0, "R6 fail pulse", fail_cnt, 1);
    check(early_fail == 0, "R6 fail after write ack", early_fail, 0);
  endtask

  task automatic t_timeout();
    clear_counts(); wait_lim = 0;
    for (int i = 0; i < 8; i++) script[i] = (i % 2) ? 8'h40 : 8'h00;
    pulse_start(); wait_idle();
    check(to_cnt == 1 && done_cnt == 0 && fail_cnt == 0, "R7 timeout pulse", to_cnt, 1);
    check(rd_cnt == 8 && wr_cnt == 0, "R7 timeout reads", rd_cnt, 8);
  endtask

  task automatic t_abort_resume();
    clear_counts(); wait_lim = 2;
    for (int i = 0; i < 8; i++) script[i] = (i % 2) ? 8'h40 : 8'h00;
    pulse_start();
    for (int i = 0; i < 50 && rd_cnt < 1; i++) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_idle();
    check(!busy && rd_cnt == 2, "R8 abort at read end", rd_cnt, 2);
    check(done_cnt + fail_cnt + to_cnt == 0 && wr_cnt == 0, "R8 abort no pulse",
          done_cnt + fail_cnt + to_cnt, 0);
    clear_counts(); wait_lim = 0;
    script[0] = 8'h00; script[1] = 8'h00;
    pulse_start(); wait_idle();
    check(rd_cnt == 2 && done_cnt == 1, "R8 resume from fresh pair", rd_cnt, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_steady();
    t_repoll();
    t_recheck_ok();
    t_recheck_fail();
    t_timeout();
    t_abort_resume();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule